// File: doc/BRIEF.md
# Remote Reconfiguration Register File

This block keeps the small set of registers that steer a device's remote reconfiguration. It has two clock domains. The user domain holds a serial shift chain and an update register, both clocked by user logic. The oscillator domain holds the control register and the status register, both clocked by a free-running internal oscillator. User logic shifts words in and out of the chain one bit at a time. It can capture a register into the chain, or commit the chain into the update register. What a capture reads depends on which image is running. Writes to the update register are accepted only while the factory image runs.

A reconfiguration can start from four places: a watchdog expiry, an external configuration request, a CRC failure, or a request from user logic. Any of them copies the update register into the control register and records a one-hot cause in the status register. A user request crosses into the oscillator domain through a synchronizer and an edge detector, with a handshake back. While that crossing is in flight, the update register cannot change. The control register drives the loader with a page address, a watchdog timeout and enable, and an image-kind flag.

Top module: `rcfg_regfile`

## Requirements
- R1: After reset the control word is all zeros: page address 0, watchdog off, factory image. Control word layout: bits [37:26] watchdog timeout, bit [25] watchdog enable, bits [24:1] page address, bit [0] image kind (1 = application, 0 = factory). These drive `wd_timeout`, `wd_enable`, `page_addr` and `app_image`.
- R2: While `shift_en` is high, the chain moves one bit per user clock toward bit 0. `ser_in` enters at bit 37, so a word loads LSB first, and `ser_out` always shows bit 0.
- R3: When `capture` and `shift_en` are both high in the same cycle, the capture wins and no shift happens.
- R4: A capture with `cap_status` low while the application image runs loads the control word into the chain.
- R5: A capture with `cap_status` low while the factory image runs loads the update register into the chain.
- R6: A capture with `cap_status` high loads the status code into chain bits [4:0] and clears the bits above them.
- R7: An `update` pulse while the factory image runs copies the chain into the update register.
- R8: An `update` pulse while the application image runs is ignored, and the update register keeps its value.
- R9: A reconfiguration copies the update register into the control word. A hardware cause (`wd_expire`, `crc_fail`, `pin_req`) takes effect at the oscillator edge that samples it. A user request takes effect on the third oscillator edge after the user edge that samples it, counting that edge as zero, with the default two synchronizer stages.
- R10: The status code is one-hot. Bit 0 means power-on and is the reset value, bit 1 means user request, bit 2 means watchdog, bit 3 means CRC, and bit 4 means external pin. When causes coincide, the priority is pin, then CRC, then watchdog, then user.
- R11: From the user edge that accepts a request through the ninth user edge after it, `update` pulses and further `reconf_req` pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| usr_clk | input | 1 | User-domain clock |
| usr_rst_n | input | 1 | User-domain synchronous active-low reset |
| osc_clk | input | 1 | Internal oscillator clock |
| osc_rst_n | input | 1 | Oscillator-domain synchronous active-low reset |
| shift_en | input | 1 | Shift the chain by one bit |
| ser_in | input | 1 | Serial data into chain bit 37 |
| ser_out | output | 1 | Chain bit 0 |
| capture | input | 1 | Load a register into the chain |
| cap_status | input | 1 | Capture selects the status code instead of the configuration word |
| update | input | 1 | Commit the chain to the update register |
| reconf_req | input | 1 | User reconfiguration request (user domain) |
| wd_expire | input | 1 | Watchdog expiry pulse (oscillator domain) |
| crc_fail | input | 1 | CRC failure pulse (oscillator domain) |
| pin_req | input | 1 | External configuration request pulse (oscillator domain) |
| page_addr | output | 24 | Page address for the loader |
| wd_timeout | output | 12 | Watchdog timeout setting |
| wd_enable | output | 1 | Watchdog enable |
| app_image | output | 1 | 1 when the application image is selected |
| reconf_cause | output | 5 | One-hot cause of the last reconfiguration |

## Verification
The bench builds the block with a 12-bit timeout, a 24-bit page address and two synchronizer stages. With these defaults the chain is 38 bits long, so full words can be shifted through in a short run. The bench drives both domains from one clock. That makes the latency of the request handshake deterministic, so the bench can predict the exact edge at which the control word changes and the edge at which the update lock is released. Coinciding hardware causes and a capture issued together with a shift bring the priority rules within reach.

// File: rtl/rcfg_pkg.sv
// Shared definitions for the remote reconfiguration register file.
// Assumes a 5-bit one-hot cause code; index constants fix the bit order.
package rcfg_pkg;

    localparam int CAUSE_W  = 5;
    localparam int CS_POR   = 0;
    localparam int CS_USER  = 1;
    localparam int CS_WDOG  = 2;
    localparam int CS_CRC   = 3;
    localparam int CS_PIN   = 4;

    typedef logic [CAUSE_W-1:0] cause_t;

    // Choose one cause by priority: pin, CRC, watchdog, user.
    function automatic cause_t pick_cause(input logic pin, input logic crc,
                                          input logic wdog, input logic user);
        cause_t c;
        c = '0;
        if (pin)       c[CS_PIN]  = 1'b1;
        else if (crc)  c[CS_CRC]  = 1'b1;
        else if (wdog) c[CS_WDOG] = 1'b1;
        else if (user) c[CS_USER] = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/rcfg_sync.sv
// Multi-stage synchronizer for a quasi-static or level signal.
// Assumes STAGES >= 2; each bit is synchronized independently.
module rcfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain;

    // Move the sampled value one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-W-1:0], d};
    end

    assign q = chain[CHAIN_W-1 -: W];

endmodule

// File: rtl/rcfg_req_xfer.sv
// Carries a user reconfiguration request into the oscillator domain.
// A user-side flag is synchronized across, its rising edge fires one
// oscillator pulse, and the synchronized level returns as an acknowledge.
// The request is pending until the acknowledge has risen and fallen again.
module rcfg_req_xfer #(
    parameter int SYNC_STAGES = 2
) (
    input  logic u_clk,
    input  logic u_rst_n,
    input  logic o_clk,
    input  logic o_rst_n,
    input  logic req_in,
    output logic pending,
    output logic fire
);

    logic req_flag;
    logic req_o;
    logic req_o_d;
    logic ack_u;

    // Raise the flag on a new request; drop it once it is acknowledged.
    always_ff @(posedge u_clk) begin
        if (!u_rst_n)                req_flag <= 1'b0;
        else if (req_flag && ack_u)  req_flag <= 1'b0;
        else if (req_in && !pending) req_flag <= 1'b1;
    end

    rcfg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_fwd (
        .clk(o_clk), .rst_n(o_rst_n), .d(req_flag), .q(req_o)
    );

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge o_clk) begin
        if (!o_rst_n) req_o_d <= 1'b0;
        else          req_o_d <= req_o;
    end

    rcfg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_back (
        .clk(u_clk), .rst_n(u_rst_n), .d(req_o), .q(ack_u)
    );

    assign fire    = req_o && !req_o_d;
    assign pending = req_flag || ack_u;

endmodule

// File: rtl/rcfg_user_regs.sv
// User-clock registers: the serial chain and the update register.
// Assumes the control and status words are quasi-static when sampled:
// they only change on a reconfiguration, while this domain is idle or
// locked. Capture has priority over shift; update reads the pre-edge chain.
module rcfg_user_regs
    import rcfg_pkg::*;
#(
    parameter int CTRL_W = 38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              ser_in,
    input  logic              capture,
    input  logic              cap_status,
    input  logic              update,
    input  logic              app_mode,
    input  logic              lock,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  cause_t            stat_word,
    output logic              ser_out,
    output logic [CTRL_W-1:0] shift_q,
    output logic [CTRL_W-1:0] upd_q
);

    localparam int PAD_W = CTRL_W - CAUSE_W;

    logic [CTRL_W-1:0] cap_word;
    logic              upd_ok;

    // Pick the capture source from the select line and the running image.
    always_comb begin
        if (cap_status)    cap_word = {{PAD_W{1'b0}}, stat_word};
        else if (app_mode) cap_word = ctrl_word;
        else               cap_word = upd_q;
    end

    assign upd_ok = update && !app_mode && !lock;

    // Serial chain: capture first, otherwise shift toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        shift_q <= '0;
        else if (capture)  shift_q <= cap_word;
        else if (shift_en) shift_q <= {ser_in, shift_q[CTRL_W-1:1]};
    end

    // Update register: factory-only commit of the chain.
    always_ff @(posedge clk) begin
        if (!rst_n)      upd_q <= '0;
        else if (upd_ok) upd_q <= shift_q;
    end

    assign ser_out = shift_q[0];

endmodule

// File: rtl/rcfg_osc_regs.sv
// Oscillator-clock registers: control word and status cause.
// Assumes hardware causes are single-cycle pulses in this domain and that
// the update word is stable whenever a user request fires.
module rcfg_osc_regs
    import rcfg_pkg::*;
#(
    parameter int CTRL_W = 38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] upd_word,
    input  logic              fire_user,
    input  logic              wd_expire,
    input  logic              crc_fail,
    input  logic              pin_req,
    output logic [CTRL_W-1:0] ctrl_q,
    output cause_t            stat_q
);

    cause_t next_cause;
    logic   any_ev;

    assign next_cause = pick_cause(pin_req, crc_fail, wd_expire, fire_user);
    assign any_ev     = |next_cause;

    // Control word: cleared at power-up, reloaded on each reconfiguration.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (any_ev) ctrl_q <= upd_word;
    end

    // Status word: power-on at reset, then the latest cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q         <= '0;
            stat_q[CS_POR] <= 1'b1;
        end else if (any_ev) begin
            stat_q <= next_cause;
        end
    end

endmodule

// File: rtl/rcfg_regfile.sv
// Remote reconfiguration register file, top level.
// Assumes usr_clk and osc_clk may be unrelated; only the request level and
// the image-kind bit cross through synchronizers, and the wide words are
// read only while they are held still.
module rcfg_regfile
    import rcfg_pkg::*;
#(
    parameter int WD_W        = 12,
    parameter int PAGE_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              usr_clk,
    input  logic              usr_rst_n,
    input  logic              osc_clk,
    input  logic              osc_rst_n,
    input  logic              shift_en,
    input  logic              ser_in,
    output logic              ser_out,
    input  logic              capture,
    input  logic              cap_status,
    input  logic              update,
    input  logic              reconf_req,
    input  logic              wd_expire,
    input  logic              crc_fail,
    input  logic              pin_req,
    output logic [PAGE_W-1:0] page_addr,
    output logic [WD_W-1:0]   wd_timeout,
    output logic              wd_enable,
    output logic              app_image,
    output logic [CAUSE_W-1:0] reconf_cause
);

    localparam int CTRL_W   = WD_W + PAGE_W + 2;
    localparam int PAGE_LSB = 1;
    localparam int WDEN_BIT = PAGE_W + 1;
    localparam int WD_LSB   = PAGE_W + 2;

    logic [CTRL_W-1:0] shift_q;
    logic [CTRL_W-1:0] upd_q;
    logic [CTRL_W-1:0] ctrl_q;
    cause_t            stat_q;
    logic              app_u;
    logic              pending;
    logic              fire_user;

    rcfg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_mode_sync (
        .clk(usr_clk), .rst_n(usr_rst_n), .d(ctrl_q[0]), .q(app_u)
    );

    rcfg_req_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
        .u_clk(usr_clk), .u_rst_n(usr_rst_n),
        .o_clk(osc_clk), .o_rst_n(osc_rst_n),
        .req_in(reconf_req), .pending(pending), .fire(fire_user)
    );

    rcfg_user_regs #(.CTRL_W(CTRL_W)) u_user (
        .clk(usr_clk), .rst_n(usr_rst_n),
        .shift_en(shift_en), .ser_in(ser_in),
        .capture(capture), .cap_status(cap_status), .update(update),
        .app_mode(app_u), .lock(pending),
        .ctrl_word(ctrl_q), .stat_word(stat_q),
        .ser_out(ser_out), .shift_q(shift_q), .upd_q(upd_q)
    );

    rcfg_osc_regs #(.CTRL_W(CTRL_W)) u_osc (
        .clk(osc_clk), .rst_n(osc_rst_n),
        .upd_word(upd_q), .fire_user(fire_user),
        .wd_expire(wd_expire), .crc_fail(crc_fail), .pin_req(pin_req),
        .ctrl_q(ctrl_q), .stat_q(stat_q)
    );

    assign page_addr    = ctrl_q[PAGE_LSB +: PAGE_W];
    assign wd_enable    = ctrl_q[WDEN_BIT];
    assign wd_timeout   = ctrl_q[WD_LSB +: WD_W];
    assign app_image    = ctrl_q[0];
    assign reconf_cause = stat_q;

endmodule

// File: rtl/rcfg_regfile_chk.sv
// Property checker for rcfg_regfile, attached with bind.
// Assumes it sees the top's internal chain, update, control and status words.
module rcfg_regfile_chk #(
    parameter int CTRL_W = 38
) (
    input logic              usr_clk,
    input logic              usr_rst_n,
    input logic              osc_clk,
    input logic              osc_rst_n,
    input logic              shift_en,
    input logic              capture,
    input logic              update,
    input logic              ser_out,
    input logic              wd_expire,
    input logic              crc_fail,
    input logic              pin_req,
    input logic              app_u,
    input logic              pending,
    input logic [CTRL_W-1:0] shift_q,
    input logic [CTRL_W-1:0] upd_q,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [4:0]        stat_q
);

    // R10
    stat_onehot_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        $countones(stat_q) == 1);

    // R8
    app_update_ignored_chk: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
        (update && app_u) |=> $stable(upd_q));

    // R11
    pending_hold_chk: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
        pending |=> $stable(upd_q));

    // R9
    hw_transfer_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        (wd_expire || crc_fail || pin_req) |=> (ctrl_q == $past(upd_q)));

    // R2
    shift_step_chk: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
        (shift_en && !capture) |=> (ser_out == $past(shift_q[1])));

endmodule

bind rcfg_regfile rcfg_regfile_chk #(.CTRL_W(CTRL_W)) u_chk (
    .usr_clk(usr_clk), .usr_rst_n(usr_rst_n),
    .osc_clk(osc_clk), .osc_rst_n(osc_rst_n),
    .shift_en(shift_en), .capture(capture), .update(update),
    .ser_out(ser_out), .wd_expire(wd_expire), .crc_fail(crc_fail),
    .pin_req(pin_req), .app_u(app_u), .pending(pending),
    .shift_q(shift_q), .upd_q(upd_q), .ctrl_q(ctrl_q), .stat_q(stat_q)
);

// File: tb/rcfg_regfile_test.sv
// Bench for rcfg_regfile: a behavioural model stepped on every edge and
// compared on every falling edge, plus named checks at scenario ends.
module rcfg_regfile_test;

    localparam int W = 38;
    localparam int S = 2;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_en = 0, ser_in = 0, capture = 0, cap_status = 0, update = 0;
    logic reconf_req = 0, wd_expire = 0, crc_fail = 0, pin_req = 0;
    logic        ser_out, wd_enable, app_image;
    logic [23:0] page_addr;
    logic [11:0] wd_timeout;
    logic [4:0]  reconf_cause;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rcfg_regfile uut (
        .usr_clk(clk), .usr_rst_n(rst_n), .osc_clk(clk), .osc_rst_n(rst_n),
        .shift_en(shift_en), .ser_in(ser_in), .ser_out(ser_out),
        .capture(capture), .cap_status(cap_status), .update(update),
        .reconf_req(reconf_req), .wd_expire(wd_expire), .crc_fail(crc_fail),
        .pin_req(pin_req), .page_addr(page_addr), .wd_timeout(wd_timeout),
        .wd_enable(wd_enable), .app_image(app_image), .reconf_cause(reconf_cause)
    );

    // ---------------- behavioural model ----------------
    logic [W-1:0] m_shift, m_upd, m_ctrl;
    logic [4:0]   m_stat;
    logic         m_m1, m_mode;
    int           fire_cnt, pend;

    always @(posedge clk) begin
        logic [W-1:0] n_shift, n_upd;
        logic         ufire;
        if (!rst_n) begin
            m_shift = '0; m_upd = '0; m_ctrl = '0; m_stat = 5'b00001;
            m_m1 = 0; m_mode = 0; fire_cnt = 0; pend = 0;
        end else begin
            n_shift = m_shift;
            if (capture)
                n_shift = cap_status ? W'(m_stat) : (m_mode ? m_ctrl : m_upd);
            else if (shift_en)
                n_shift = {ser_in, m_shift[W-1:1]};
            n_upd = m_upd;
            if (update && !m_mode && pend == 0) n_upd = m_shift;
            ufire = (fire_cnt == 1);
            m_mode = m_m1;
            m_m1   = m_ctrl[0];
            if (pin_req || crc_fail || wd_expire || ufire) begin
                m_ctrl = m_upd;
                m_stat = pin_req ? 5'b10000 : crc_fail ? 5'b01000 :
                         wd_expire ? 5'b00100 : 5'b00010;
            end
            if (fire_cnt > 0) fire_cnt--;
            if (pend > 0) pend--;
            else if (reconf_req) begin fire_cnt = S + 1; pend = 4 * S + 1; end
            m_shift = n_shift;
            m_upd   = n_upd;
        end
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 ser_out", 64'(ser_out), 64'(m_shift[0]));
            check("R9 page_addr", 64'(page_addr), 64'(m_ctrl[24:1]));
            check("R9 wd_timeout", 64'(wd_timeout), 64'(m_ctrl[37:26]));
            check("R9 wd_enable", 64'(wd_enable), 64'(m_ctrl[25]));
            check("R9 app_image", 64'(app_image), 64'(m_ctrl[0]));
            check("R10 reconf_cause", 64'(reconf_cause), 64'(m_stat));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_chain(input logic [W-1:0] w);
        for (int i = 0; i < W; i++) begin
            @(negedge clk); ser_in = w[i]; shift_en = 1;
        end
        @(negedge clk); shift_en = 0; ser_in = 0;
    endtask

    task automatic read_chain(output logic [W-1:0] w);
        for (int i = 0; i < W; i++) begin
            @(negedge clk); w[i] = ser_out; shift_en = 1;
        end
        @(negedge clk); shift_en = 0;
    endtask

    task automatic do_capture(input logic sel, input logic with_shift);
        @(negedge clk); capture = 1; cap_status = sel; shift_en = with_shift; ser_in = 1;
        @(negedge clk); capture = 0; cap_status = 0; shift_en = 0; ser_in = 0;
    endtask

    task automatic do_update();
        @(negedge clk); update = 1;
        @(negedge clk); update = 0;
    endtask

    logic [W-1:0] word_a, word_b, word_c, rd;

    initial begin
        word_a = {12'hA5C, 1'b1, 24'h123456, 1'b1};
        word_b = {12'h0F1, 1'b0, 24'hABCDEF, 1'b1};
        word_c = {12'h777, 1'b1, 24'h00F00D, 1'b0};

        idle(4);
        // R1 R10: reset values seen on the outputs
        check("R1 reset page", 64'(page_addr), 64'h0);
        check("R1 reset app", 64'(app_image), 64'h0);
        check("R1 reset wd_en", 64'(wd_enable), 64'h0);
        check("R10 reset cause", 64'(reconf_cause), 64'h01);
        rst_n = 1;
        idle(2);

        // R7 R5 R2: factory commit and readback of the update register
        write_chain(word_a);
        do_update();
        do_capture(1'b0, 1'b0);
        read_chain(rd);
        check("R5 factory capture", 64'(rd), 64'(word_a));

        // R6: status capture, zero-extended
        write_chain({W{1'b1}});
        do_capture(1'b1, 1'b0);
        read_chain(rd);
        check("R6 status capture", 64'(rd), 64'h01);

        // R3: capture wins over a simultaneous shift
        write_chain(word_b);
        do_capture(1'b0, 1'b1);
        read_chain(rd);
        check("R3 capture priority", 64'(rd), 64'(word_a));

        // R11: user request, then update and second request while pending
        write_chain(word_b);
        @(negedge clk); reconf_req = 1;
        @(negedge clk); reconf_req = 1; update = 1;
        @(negedge clk); reconf_req = 0; update = 0;
        idle(12);
        // R9 R1: user-requested transfer reaches the loader fields
        check("R9 user page", 64'(page_addr), 64'h123456);
        check("R1 wd_timeout", 64'(wd_timeout), 64'hA5C);
        check("R1 wd_enable", 64'(wd_enable), 64'h1);
        check("R1 app flag", 64'(app_image), 64'h1);
        check("R10 user cause", 64'(reconf_cause), 64'h02);

        // R4: application capture reads the control word
        do_capture(1'b0, 1'b0);
        read_chain(rd);
        check("R4 app capture", 64'(rd), 64'(word_a));

        // R8: update ignored in application image
        write_chain(word_c);
        do_update();
        // R8 R11: a CRC reconfiguration reloads the unchanged update word
        @(negedge clk); crc_fail = 1;
        @(negedge clk); crc_fail = 0;
        check("R8 update kept", 64'(page_addr), 64'h123456);
        check("R11 update locked", 64'(wd_timeout), 64'hA5C);
        check("R10 crc cause", 64'(reconf_cause), 64'h08);

        // R10: coinciding watchdog and pin, pin wins
        @(negedge clk); wd_expire = 1; pin_req = 1;
        @(negedge clk); wd_expire = 0; pin_req = 0;
        check("R10 priority", 64'(reconf_cause), 64'h10);
        @(negedge clk); wd_expire = 1;
        @(negedge clk); wd_expire = 0;
        check("R10 wd cause", 64'(reconf_cause), 64'h04);
        idle(4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule